// File: doc/BRIEF.md
# Clock Frequency Meter

The block measures how fast one of several monitored clocks runs compared with the clock it lives on (the reference clock). Each monitored clock drives a divide-by-two toggle in its own domain. The toggle is carried into the reference domain by a synchroniser, and every change seen there counts as one monitored cycle. When a measurement is enabled, the block latches the channel select and the cycle target. It then waits for the first synchronised edge of the chosen channel. From that edge it counts reference cycles until the target number of further monitored edges has arrived.

The count is placed in a result register and a valid flag rises. Software can derive the monitored frequency as `target * f_ref / result`. A separate free-running enable gates the whole meter: while it is low, neither reference cycles nor monitored edges are counted. Clearing the measurement enable re-arms the meter for the next run.

Top module: `freq_meter`

## Requirements
- R1: While `rst` is high, and after it until the first completion, `result` is 0 and `result_valid` is 0.
- R2: With a monitored clock whose period is exactly N reference cycles and a target T above zero, the measurement completes with `result` = T*N and `result_valid` = 1.
- R3: `chan_sel` = i selects `mon_clk[i]`. The select is sampled in the first enabled cycle after `meas_en` rises, and later changes while `meas_en` stays high do not alter the running measurement.
- R4: `cycle_target` is sampled in the same first enabled cycle, and later changes while `meas_en` stays high do not alter the running measurement.
- R5: A target of 0 completes one clock after enabling, with `result` = 0 and `result_valid` = 1.
- R6: While `frun_en` is low, no reference cycle and no monitored edge is counted. With `frun_en` low throughout, no measurement completes. A pause lasting a whole multiple of the monitored period leaves the result unchanged.
- R7: `result_valid` falls one clock after `meas_en` goes low. `result` keeps its value until the next completion.
- R8: The count saturates at all ones (65535 at the default 16-bit result width) instead of wrapping.
- R9: After completion, while `meas_en` stays high, `result_valid` stays 1 and `result` stays stable. A new measurement needs `meas_en` to be cleared first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; all control and outputs are in this domain |
| rst | input | 1 | Synchronous active-high reset (also synchronised into each monitored domain) |
| mon_clk | input | NUM_CH (4) | Monitored clocks, one per channel |
| meas_en | input | 1 | Measurement enable; rising starts, clearing re-arms |
| frun_en | input | 1 | Free-running gate; counting happens only while high |
| cycle_target | input | TGT_W (24) | Number of monitored cycles forming the window |
| chan_sel | input | SEL_W (2) | Channel index of the monitored clock |
| result | output | RES_W (16) | Reference cycles counted over the window, saturating |
| result_valid | output | 1 | High while `result` holds a finished measurement of the current run |

## Verification
The main function is tried with a table of channel and target pairs. The four monitored periods (4, 6, 9 and 13 reference cycles) with targets from 1 to 40 separate a correct per-edge count from off-by-one window errors and from the wrong channel being selected. Directed runs change the select and the target in the middle of a measurement. Their results show whether the values latched at start are used, rather than the live inputs. A pause of the free-running gate lasting exactly five monitored periods must give the same result as an unpaused run, which shows that edges and reference cycles are gated together. A long window on the slowest channel exercises saturation, and a zero target exercises the immediate-completion path.

// File: rtl/fm_pkg.sv
package fm_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARM   = 2'd1,
    ST_COUNT = 2'd2,
    ST_DONE  = 2'd3
  } fm_state_e;
endpackage

// File: rtl/fm_mon_toggle.sv
module fm_mon_toggle #(
  parameter int RST_STAGES = 2
) (
  input  logic mon_clk,
  input  logic rst,
  output logic tog
);
  logic [RST_STAGES-1:0] rst_pipe;

  always_ff @(posedge mon_clk) begin
    rst_pipe <= {rst_pipe[RST_STAGES-2:0], rst};
  end

  always_ff @(posedge mon_clk) begin
    if (rst_pipe[RST_STAGES-1]) tog <= 1'b0;
    else                        tog <= ~tog;
  end
endmodule

// File: rtl/fm_edge_sync.sv
module fm_edge_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic tog_async,
  output logic edge_pulse
);
  logic [SYNC_STAGES:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[SYNC_STAGES-1:0], tog_async};
  end

  assign edge_pulse = chain[SYNC_STAGES] ^ chain[SYNC_STAGES-1];
endmodule

// File: rtl/fm_window_ctrl.sv
module fm_window_ctrl
  import fm_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int TGT_W  = 24,
  parameter int RES_W  = 16,
  localparam int SEL_W = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              meas_en,
  input  logic              frun_en,
  input  logic [TGT_W-1:0]  cycle_target,
  input  logic [SEL_W-1:0]  chan_sel,
  input  logic [NUM_CH-1:0] edge_vec,
  output logic [RES_W-1:0]  result,
  output logic              result_valid
);
  fm_state_e        st_q;
  logic [SEL_W-1:0] sel_q;
  logic [TGT_W-1:0] tgt_q;
  logic [TGT_W-1:0] edge_cnt;
  logic [TGT_W-1:0] edge_inc;
  logic [RES_W-1:0] cnt_q;
  logic [RES_W-1:0] cnt_nxt;
  logic [RES_W-1:0] res_q;
  logic             val_q;
  logic             sel_edge;

  assign sel_edge = edge_vec[sel_q];
  assign edge_inc = edge_cnt + TGT_W'(1);
  assign cnt_nxt  = (cnt_q == '1) ? cnt_q : cnt_q + RES_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= ST_IDLE;
      sel_q    <= '0;
      tgt_q    <= '0;
      edge_cnt <= '0;
      cnt_q    <= '0;
      res_q    <= '0;
      val_q    <= 1'b0;
    end else if (!meas_en) begin
      st_q  <= ST_IDLE;
      val_q <= 1'b0;
    end else begin
      case (st_q)
        ST_IDLE: begin
          sel_q    <= chan_sel;
          tgt_q    <= cycle_target;
          edge_cnt <= '0;
          cnt_q    <= '0;
          if (cycle_target == '0) begin
            res_q <= '0;
            val_q <= 1'b1;
            st_q  <= ST_DONE;
          end else begin
            st_q <= ST_ARM;
          end
        end
        ST_ARM: begin
          if (frun_en && sel_edge) st_q <= ST_COUNT;
        end
        ST_COUNT: begin
          if (frun_en) begin
            cnt_q <= cnt_nxt;
            if (sel_edge) begin
              edge_cnt <= edge_inc;
              if (edge_inc == tgt_q) begin
                res_q <= cnt_nxt;
                val_q <= 1'b1;
                st_q  <= ST_DONE;
              end
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign result       = res_q;
  assign result_valid = val_q;

  AST_VALID_DROPS: assert property (@(posedge clk) disable iff (rst)
    !meas_en |=> !result_valid); // R7
  AST_RESULT_ON_DONE: assert property (@(posedge clk) disable iff (rst)
    !$stable(res_q) |-> $rose(val_q)); // R7
  AST_SEL_LATCHED: assert property (@(posedge clk) disable iff (rst)
    (st_q != ST_IDLE) |=> $stable(sel_q)); // R3
  AST_TGT_LATCHED: assert property (@(posedge clk) disable iff (rst)
    (st_q != ST_IDLE) |=> $stable(tgt_q)); // R4
  AST_GATED_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!frun_en && st_q == ST_COUNT) |=> $stable(cnt_q) && $stable(edge_cnt)); // R6
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == '1 && st_q == ST_COUNT) |=> (cnt_q == '1)); // R8
  AST_DONE_STABLE: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_DONE && meas_en) |=> result_valid && $stable(result)); // R9
endmodule

// File: rtl/freq_meter.sv
module freq_meter #(
  parameter int NUM_CH      = 4,
  parameter int TGT_W       = 24,
  parameter int RES_W       = 16,
  parameter int SYNC_STAGES = 2,
  localparam int SEL_W      = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] mon_clk,
  input  logic              meas_en,
  input  logic              frun_en,
  input  logic [TGT_W-1:0]  cycle_target,
  input  logic [SEL_W-1:0]  chan_sel,
  output logic [RES_W-1:0]  result,
  output logic              result_valid
);
  logic [NUM_CH-1:0] tog_vec;
  logic [NUM_CH-1:0] edge_vec;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    fm_mon_toggle #(.RST_STAGES(2)) u_tog (
      .mon_clk (mon_clk[ch]),
      .rst     (rst),
      .tog     (tog_vec[ch])
    );
    fm_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
      .clk        (clk),
      .rst        (rst),
      .tog_async  (tog_vec[ch]),
      .edge_pulse (edge_vec[ch])
    );
  end

  fm_window_ctrl #(
    .NUM_CH (NUM_CH),
    .TGT_W  (TGT_W),
    .RES_W  (RES_W)
  ) u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .meas_en      (meas_en),
    .frun_en      (frun_en),
    .cycle_target (cycle_target),
    .chan_sel     (chan_sel),
    .edge_vec     (edge_vec),
    .result       (result),
    .result_valid (result_valid)
  );
endmodule

// File: tb/test_freq_meter.sv
`timescale 1ns/1ps
module test_freq_meter;
  localparam int NV = 8;
  // channel, target, expected result (periods 4,6,9,13 reference cycles)
  localparam int VEC [NV][3] = '{
    '{0, 1, 4}, '{0, 5, 20}, '{1, 3, 18}, '{2, 7, 63},
    '{3, 2, 26}, '{1, 40, 240}, '{2, 1, 9}, '{3, 10, 130}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        mc0 = 1'b0, mc1 = 1'b0, mc2 = 1'b0, mc3 = 1'b0;
  logic [3:0]  mon_clk;
  logic        meas_en = 1'b0;
  logic        frun_en = 1'b1;
  logic [23:0] cycle_target = '0;
  logic [1:0]  chan_sel = '0;
  logic [15:0] result;
  logic        result_valid;
  int          n_chk = 0;
  int          n_bad = 0;

  always #5 clk = ~clk;
  initial begin #3; forever #20 mc0 = ~mc0; end
  initial begin #3; forever #30 mc1 = ~mc1; end
  initial begin #3; forever #45 mc2 = ~mc2; end
  initial begin #3; forever #65 mc3 = ~mc3; end
  assign mon_clk = {mc3, mc2, mc1, mc0};

  freq_meter i_freq_meter (
    .clk(clk), .rst(rst), .mon_clk(mon_clk), .meas_en(meas_en),
    .frun_en(frun_en), .cycle_target(cycle_target), .chan_sel(chan_sel),
    .result(result), .result_valid(result_valid)
  );

  task automatic check(input string req, input longint act, input longint exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic start(input int ch, input int tgt);
    @(negedge clk);
    chan_sel = 2'(ch);
    cycle_target = 24'(tgt);
    meas_en = 1'b1;
  endtask

  task automatic wait_valid(input int limit, input string req);
    int n = 0;
    while (!result_valid && n < limit) begin
      @(negedge clk);
      n++;
    end
    if (!result_valid) begin
      n_chk++;
      n_bad++;
      $display("FAIL %s: got no completion expected valid within %0d cycles", req, limit);
    end
  endtask

  task automatic stop_and_check(input int held);
    @(negedge clk);
    meas_en = 1'b0;
    @(negedge clk);
    check("R7 valid clears", result_valid, 0);
    check("R7 result held", result, held);
  endtask

  initial begin
    repeat (40) @(negedge clk);
    check("R1 reset result", result, 0);
    check("R1 reset valid", result_valid, 0);
    rst = 1'b0;
    repeat (5) @(negedge clk);
    check("R1 idle valid", result_valid, 0);

    // R2 R3 table walk
    for (int i = 0; i < NV; i++) begin
      start(VEC[i][0], VEC[i][1]);
      wait_valid(2000, "R2");
      check("R2 table result", result, VEC[i][2]);
      stop_and_check(VEC[i][2]);
    end

    // R5 zero target
    start(1, 0);
    @(negedge clk);
    check("R5 zero valid", result_valid, 1);
    check("R5 zero result", result, 0);
    stop_and_check(0);

    // R3 select change ignored
    start(0, 20);
    repeat (10) @(negedge clk);
    chan_sel = 2'd3;
    wait_valid(2000, "R3");
    check("R3 select latched", result, 80);
    stop_and_check(80);

    // R4 target change ignored
    start(1, 10);
    repeat (5) @(negedge clk);
    cycle_target = 24'd2;
    wait_valid(2000, "R4");
    check("R4 target latched", result, 60);

    // R9 hold after completion
    chan_sel = 2'd0;
    cycle_target = 24'd1;
    repeat (100) @(negedge clk);
    check("R9 valid held", result_valid, 1);
    check("R9 result held", result, 60);
    stop_and_check(60);

    // R6 gate low throughout
    frun_en = 1'b0;
    start(0, 2);
    repeat (200) @(negedge clk);
    check("R6 no completion gated", result_valid, 0);
    frun_en = 1'b1;
    wait_valid(2000, "R6");
    check("R6 result after ungate", result, 8);
    stop_and_check(8);

    // R6 pause of five periods on channel 2
    start(2, 20);
    repeat (30) @(negedge clk);
    frun_en = 1'b0;
    repeat (45) @(negedge clk);
    frun_en = 1'b1;
    wait_valid(3000, "R6");
    check("R6 paused result", result, 180);
    stop_and_check(180);

    // R8 saturation: 6000 * 13 exceeds 65535
    start(3, 6000);
    wait_valid(100000, "R8");
    check("R8 saturated result", result, 65535);
    stop_and_check(65535);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule